// File: doc/BRIEF.md
# Hierarchical Adaptive Route Selector

This block decides which of the sixteen output ports of a network switch a packet leaves by. When the head of a packet shows up, the block splits the destination identifier into a group field and a local field. If the group is not the switch's own group, a small group-level table is read. If the group is the switch's own, a larger local-level table is read instead. Each table entry is a mask of the ports that may carry the packet onward. Because the tables follow the packaging hierarchy, they need far fewer entries than one flat table indexed by the full identifier.

The mask is ANDed with a port-enable mask that software keeps up to date. Ports that are cleared there, such as faulty links, are never used. Among the candidates that remain, the block picks the port with the most free downstream credits. When several ports tie, a rotating pointer decides, so that traffic spreads evenly. The answer comes out registered, one cycle after the head strobe. If no candidate is left, the block reports a route error. A write port loads the tables during configuration.

Top module: `route_selector`

## Requirements
- R1: While reset is asserted and after it is released, res_valid, res_err and res_port are 0. Every table entry is cleared to an empty mask, so a lookup before any write reports a route error.
- R2: A head strobe sampled on a rising edge gives res_valid = 1 for exactly the next cycle. With no strobe, res_valid stays 0.
- R3: dest_id[ID_W-1:LOC_W] is the group field and dest_id[LOC_W-1:0] is the local field. If the group field differs from self_group, the group-level table is read at that group. Otherwise the local-level table is read at the local field.
- R4: The table mask is ANDed with port_en (bit p enables port p). A port whose enable bit is 0 in the head cycle is never reported.
- R5: Among the remaining candidates, the reported port has the largest credit count. The count for port p is credit_vec[p*CRED_W +: CRED_W], as present in the head cycle.
- R6: Among tied candidates, the first one at or above the rotating pointer wins, counting upward and wrapping. The pointer is 0 after reset. After each successful selection it becomes the chosen port plus one, modulo the port count. It is unchanged after a route error.
- R7: If no enabled candidate remains, res_err = 1 and res_port = 0 in the result cycle.
- R8: With tbl_we = 1, tbl_mask is written on the rising edge. It goes to the local-level table when tbl_level = 0 and to the group-level table when tbl_level = 1, at tbl_addr; the group level uses only the low GRP_W address bits. A head sampled on the same edge as a write sees the old entry. The next head sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_group | input | GRP_W | Group field of this switch's own identifier |
| head_valid | input | 1 | Packet head present this cycle |
| dest_id | input | GRP_W+LOC_W | Destination identifier: group field above local field |
| credit_vec | input | NUM_PORTS*CRED_W | Free downstream credits, one field per port |
| port_en | input | NUM_PORTS | Port enable mask; 0 marks a port unusable |
| tbl_we | input | 1 | Table write strobe |
| tbl_level | input | 1 | 0 = local-level table, 1 = group-level table |
| tbl_addr | input | max(GRP_W,LOC_W) | Table entry to write |
| tbl_mask | input | NUM_PORTS | Candidate port mask to store |
| res_valid | output | 1 | Result present (one cycle after head) |
| res_port | output | $clog2(NUM_PORTS) | Chosen output port |
| res_err | output | 1 | No enabled candidate for this head |

## Verification
The assertions take for granted that port_en is stable enough to be compared one cycle later through its sampled past value. They also assume that reset is held for at least one edge before the first head strobe. The bench drives every input on the falling edge and holds each head strobe for a single cycle, which keeps it within those assumptions. It also scrambles the credit inputs right after each head edge, which shows that only the values present in the head cycle count. The tables are loaded with random masks and every destination identifier is swept against an independent model. Port enables are randomized to mark faulty ports, and narrow credit ranges are used to force ties.

// File: rtl/rsel_pkg.sv
`timescale 1ns/1ps
package rsel_pkg;

   // which of the two routing tables a write or lookup addresses
   typedef enum logic {
      LVL_LOCAL = 1'b0,
      LVL_GROUP = 1'b1
   } rsel_level_e;

   function automatic int unsigned rsel_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rsel_table.sv
`timescale 1ns/1ps
// Generic mask storage: one register per entry, write port plus async read.
module rsel_table #(
   parameter int unsigned ENTRIES        = 8,
   parameter int unsigned DW             = 16,
   parameter bit          CLEAR_ON_RESET = 1'b1,
   localparam int unsigned AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic hit;
      assign hit = we && (waddr == AW'(e));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)   mem_q[e] <= '0;
            else if (hit) mem_q[e] <= wdata;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit) mem_q[e] <= wdata;
         end
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/rsel_level_sel.sv
`timescale 1ns/1ps
// Splits the destination identifier and chooses which level answers.
module rsel_level_sel #(
   parameter int unsigned GRP_W = 3,
   parameter int unsigned LOC_W = 5,
   parameter int unsigned NP    = 16,
   localparam int unsigned ID_W = GRP_W + LOC_W
) (
   input  logic [ID_W-1:0]  dest_id,
   input  logic [GRP_W-1:0] self_group,
   output logic [GRP_W-1:0] grp_idx,
   output logic [LOC_W-1:0] loc_idx,
   input  logic [NP-1:0]    grp_mask,
   input  logic [NP-1:0]    loc_mask,
   output logic [NP-1:0]    route_mask
);
   import rsel_pkg::*;

   rsel_level_e lvl;

   assign grp_idx = dest_id[ID_W-1:LOC_W];
   assign loc_idx = dest_id[LOC_W-1:0];

   always_comb begin
      lvl = (grp_idx != self_group) ? LVL_GROUP : LVL_LOCAL;
      unique case (lvl)
         LVL_GROUP: route_mask = grp_mask;
         default:   route_mask = loc_mask;
      endcase
   end

endmodule

// File: rtl/rsel_pick.sv
`timescale 1ns/1ps
// Load-based utility: most credits wins, ties go round-robin from a pointer.
module rsel_pick #(
   parameter int unsigned NP     = 16,
   parameter int unsigned CRED_W = 6,
   localparam int unsigned PTR_W = $clog2(NP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [NP-1:0]      cand,
   input  logic [NP*CRED_W-1:0] cred_flat,
   output logic [PTR_W-1:0]   sel_port,
   output logic               sel_none
);

   logic [CRED_W-1:0] cred   [NP];
   logic [CRED_W-1:0] best;
   logic [NP-1:0]     tie;
   logic [PTR_W-1:0]  rr_q;
   logic              found;
   logic [PTR_W-1:0]  idx;

   for (genvar p = 0; p < NP; p++) begin : g_unpack
      assign cred[p] = cred_flat[p*CRED_W +: CRED_W];
   end

   // highest credit count among live candidates
   always_comb begin
      best = '0;
      for (int k = 0; k < NP; k++) begin
         if (cand[k] && (cred[k] > best)) best = cred[k];
      end
   end

   for (genvar p = 0; p < NP; p++) begin : g_tie
      assign tie[p] = cand[p] && (cred[p] == best);
   end

   // rotating scan starting at the pointer
   always_comb begin
      found    = 1'b0;
      sel_port = '0;
      idx      = '0;
      for (int k = 0; k < NP; k++) begin
         idx = rr_q + PTR_W'(k);
         if (!found && tie[idx]) begin
            found    = 1'b1;
            sel_port = idx;
         end
      end
   end

   assign sel_none = ~|cand;

   always_ff @(posedge clk) begin
      if (!rst_n)                rr_q <= '0;
      else if (fire && !sel_none) rr_q <= sel_port + PTR_W'(1);
   end

endmodule

// File: rtl/route_selector.sv
`timescale 1ns/1ps
module route_selector
   import rsel_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 16,
   parameter int unsigned GRP_W     = 3,
   parameter int unsigned LOC_W     = 5,
   parameter int unsigned CRED_W    = 6,
   localparam int unsigned PTR_W    = $clog2(NUM_PORTS),
   localparam int unsigned ID_W     = GRP_W + LOC_W,
   localparam int unsigned ADDR_W   = rsel_max(GRP_W, LOC_W),
   localparam int unsigned GRP_N    = 1 << GRP_W,
   localparam int unsigned LOC_N    = 1 << LOC_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [GRP_W-1:0]          self_group,
   input  logic                      head_valid,
   input  logic [ID_W-1:0]           dest_id,
   input  logic [NUM_PORTS*CRED_W-1:0] credit_vec,
   input  logic [NUM_PORTS-1:0]      port_en,
   input  logic                      tbl_we,
   input  logic                      tbl_level,
   input  logic [ADDR_W-1:0]         tbl_addr,
   input  logic [NUM_PORTS-1:0]      tbl_mask,
   output logic                      res_valid,
   output logic [PTR_W-1:0]          res_port,
   output logic                      res_err
);

   // elaboration-time parameter checks
   if (NUM_PORTS < 2 || (NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
      $error("route_selector: NUM_PORTS must be a power of two, at least 2");
   end
   if (GRP_W < 1 || LOC_W < 1) begin : g_bad_id
      $error("route_selector: identifier fields need at least one bit each");
   end
   if (CRED_W < 1) begin : g_bad_cred
      $error("route_selector: CRED_W must be at least 1");
   end

   logic [GRP_W-1:0]     grp_idx;
   logic [LOC_W-1:0]     loc_idx;
   logic [NUM_PORTS-1:0] grp_mask, loc_mask, route_mask, cand;
   logic                 grp_we, loc_we;
   logic [PTR_W-1:0]     pick_port;
   logic                 pick_none;

   assign grp_we = tbl_we && (rsel_level_e'(tbl_level) == LVL_GROUP);
   assign loc_we = tbl_we && (rsel_level_e'(tbl_level) == LVL_LOCAL);

   rsel_table #(.ENTRIES(GRP_N), .DW(NUM_PORTS)) i_grp_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (grp_we),
      .waddr (tbl_addr[GRP_W-1:0]),
      .wdata (tbl_mask),
      .raddr (grp_idx),
      .rdata (grp_mask)
   );

   rsel_table #(.ENTRIES(LOC_N), .DW(NUM_PORTS)) i_loc_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (loc_we),
      .waddr (tbl_addr[LOC_W-1:0]),
      .wdata (tbl_mask),
      .raddr (loc_idx),
      .rdata (loc_mask)
   );

   rsel_level_sel #(.GRP_W(GRP_W), .LOC_W(LOC_W), .NP(NUM_PORTS)) i_lvl (
      .dest_id    (dest_id),
      .self_group (self_group),
      .grp_idx    (grp_idx),
      .loc_idx    (loc_idx),
      .grp_mask   (grp_mask),
      .loc_mask   (loc_mask),
      .route_mask (route_mask)
   );

   assign cand = route_mask & port_en;

   rsel_pick #(.NP(NUM_PORTS), .CRED_W(CRED_W)) i_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (head_valid),
      .cand      (cand),
      .cred_flat (credit_vec),
      .sel_port  (pick_port),
      .sel_none  (pick_none)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_port  <= '0;
         res_err   <= 1'b0;
      end else begin
         res_valid <= head_valid;
         res_err   <= head_valid && pick_none;
         res_port  <= (head_valid && !pick_none) ? pick_port : '0;
      end
   end

endmodule

// File: rtl/rsel_checker.sv
`timescale 1ns/1ps
module rsel_checker #(
   parameter int unsigned NUM_PORTS = 16,
   localparam int unsigned PTR_W    = $clog2(NUM_PORTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 head_valid,
   input logic [NUM_PORTS-1:0] port_en,
   input logic                 res_valid,
   input logic [PTR_W-1:0]     res_port,
   input logic                 res_err
);

   p_head_gives_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |=> res_valid);

   p_no_head_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !head_valid |=> !res_valid);

   p_disabled_never_chosen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |=> (res_err || ((($past(port_en) >> res_port) & NUM_PORTS'(1)) != '0)));

   p_err_port_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_port == '0));

   p_err_only_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> res_valid);

endmodule

bind route_selector rsel_checker #(.NUM_PORTS(NUM_PORTS)) i_rsel_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .head_valid (head_valid),
   .port_en    (port_en),
   .res_valid  (res_valid),
   .res_port   (res_port),
   .res_err    (res_err)
);

// File: tb/test_route_selector.sv
`timescale 1ns/1ps
module test_route_selector;

   localparam int NP = 16, GW = 3, LW = 5, CW = 6, PW = 4, IW = 8, AW = 5;
   localparam int VW = 8 + 16 + 1 + 4 + 1 + 4;

   // vector: dest, port_en, hot_valid, hot_port, exp_err, exp_port
   // tables: local[3]=00F0, group[5]=0303, local[7]=0000; self_group=2; pointer 0 at start
   localparam logic [VW-1:0] VEC [8] = '{
      {8'h43, 16'hFFFF, 1'b0, 4'd0, 1'b0, 4'd4},  // R3 local level, R6 tie from 0
      {8'h43, 16'hFFFF, 1'b0, 4'd0, 1'b0, 4'd5},  // R6 pointer now 5
      {8'h43, 16'hFFFF, 1'b1, 4'd7, 1'b0, 4'd7},  // R5 most credits
      {8'h43, 16'hFF7F, 1'b1, 4'd7, 1'b0, 4'd4},  // R4 port 7 off, R6 wrap from 8
      {8'hA3, 16'hFFFF, 1'b1, 4'd9, 1'b0, 4'd9},  // R3 group level, R5
      {8'hA3, 16'hFCFC, 1'b0, 4'd0, 1'b1, 4'd0},  // R7 all masked
      {8'h47, 16'hFFFF, 1'b0, 4'd0, 1'b1, 4'd0},  // R7 empty entry
      {8'hA3, 16'hFFFF, 1'b0, 4'd0, 1'b0, 4'd0}   // R6 pointer 10 wraps to 0
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [GW-1:0]     self_group = 3'd2;
   logic              head_valid = 1'b0;
   logic [IW-1:0]     dest_id = '0;
   logic [NP*CW-1:0]  credit_vec = '0;
   logic [NP-1:0]     port_en = '1;
   logic              tbl_we = 1'b0;
   logic              tbl_level = 1'b0;
   logic [AW-1:0]     tbl_addr = '0;
   logic [NP-1:0]     tbl_mask = '0;
   logic              res_valid;
   logic [PW-1:0]     res_port;
   logic              res_err;

   int n_chk = 0, n_fail = 0;
   int mrr = 0;
   logic [NP-1:0] sh_loc [32];
   logic [NP-1:0] sh_grp [8];

   always #10 clk = ~clk;

   route_selector i_route_selector (
      .clk(clk), .rst_n(rst_n), .self_group(self_group), .head_valid(head_valid),
      .dest_id(dest_id), .credit_vec(credit_vec), .port_en(port_en),
      .tbl_we(tbl_we), .tbl_level(tbl_level), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask),
      .res_valid(res_valid), .res_port(res_port), .res_err(res_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [NP*CW-1:0] flat_cred(input bit hv, input int hp);
      logic [NP*CW-1:0] v;
      for (int p = 0; p < NP; p++) v[p*CW +: CW] = (hv && p == hp) ? CW'(20) : CW'(10);
      return v;
   endfunction

   // returns port, or -1 when nothing is left; independent scan formulation
   function automatic int model(input logic [NP-1:0] m, input logic [NP*CW-1:0] c, input int rr);
      int bp = -1, bc = -1;
      for (int k = 0; k < NP; k++) begin
         int p = (rr + k) % NP;
         int cv = int'(c[p*CW +: CW]);
         if (m[p] && cv > bc) begin bc = cv; bp = p; end
      end
      return bp;
   endfunction

   task automatic wr(input bit lvl, input int a, input logic [NP-1:0] m);
      tbl_we = 1'b1; tbl_level = lvl; tbl_addr = AW'(a); tbl_mask = m;
      if (lvl) sh_grp[a] = m; else sh_loc[a] = m;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // drive a head at a falling edge; returns at the falling edge where the result is stable
   task automatic head(input logic [IW-1:0] d, input logic [NP-1:0] en, input logic [NP*CW-1:0] c);
      dest_id = d; port_en = en; credit_vec = c; head_valid = 1'b1;
      @(negedge clk);
      head_valid = 1'b0;
      tbl_we = 1'b0;
      credit_vec = {$urandom(), $urandom(), $urandom()};  // R5: later credits must not matter
      port_en = 16'(~en);
   endtask

   function automatic logic [NP-1:0] lookup(input logic [IW-1:0] d);
      return (d[IW-1:LW] != self_group) ? sh_grp[d[IW-1:LW]] : sh_loc[d[LW-1:0]];
   endfunction

   initial begin : watchdog
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 32; i++) sh_loc[i] = '0;
      for (int i = 0; i < 8; i++) sh_grp[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(res_valid == 0 && res_err == 0 && res_port == 0, "R1 outputs in reset",
          int'({res_valid, res_err, res_port}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(res_valid == 0, "R1 idle after reset", int'(res_valid), 0);
      // R1 empty tables -> route error, pointer untouched
      head(8'h43, 16'hFFFF, flat_cred(0, 0));
      chk(res_valid && res_err && res_port == 0, "R1 empty table error",
          int'({res_valid, res_err, res_port}), 6'b110000);
      @(negedge clk);
      // R2 no strobe, no result
      chk(res_valid == 0, "R2 single-cycle valid", int'(res_valid), 0);

      // R8 table programming
      wr(1'b0, 3, 16'h00F0);
      wr(1'b1, 5, 16'h0303);
      wr(1'b0, 7, 16'h0000);

      // directed vector table
      for (int v = 0; v < 8; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         head(e[VW-1 -: 8], e[VW-9 -: 16], flat_cred(e[9], int'(e[8:5])));
         chk(res_valid == 1, $sformatf("R2 vector %0d valid", v), int'(res_valid), 1);
         chk(res_err == e[4], $sformatf("R7 vector %0d error flag", v), int'(res_err), int'(e[4]));
         chk(res_port == e[3:0], $sformatf("R3/R4/R5/R6 vector %0d port", v),
             int'(res_port), int'(e[3:0]));
         if (!e[4]) mrr = (int'(e[3:0]) + 1) % NP;
      end

      // R8 write on the same edge as a head: old entry used, new one next time
      tbl_we = 1'b1; tbl_level = 1'b0; tbl_addr = 5'd3; tbl_mask = 16'h0001;
      begin
         int ex;
         ex = model(16'h00F0, flat_cred(0, 0), mrr);
         head(8'h43, 16'hFFFF, flat_cred(0, 0));
         sh_loc[3] = 16'h0001;
         chk(int'(res_port) == ex && !res_err, "R8 head sees old entry", int'(res_port), ex);
         mrr = (ex + 1) % NP;
      end
      head(8'h43, 16'hFFFF, flat_cred(0, 0));
      chk(res_port == 0 && !res_err, "R8 next head sees new entry", int'(res_port), 0);
      mrr = 1;

      // random tables, then sweep every destination identifier against the model
      for (int i = 0; i < 32; i++) wr(1'b0, i, 16'($urandom()));
      for (int i = 0; i < 8; i++)  wr(1'b1, i, 16'($urandom()));
      for (int id = 0; id < 256; id++) begin
         logic [NP-1:0]    en;
         logic [NP*CW-1:0] c;
         int ex;
         en = 16'($urandom() | $urandom());
         if (id % 16 == 5) en = '0;
         for (int p = 0; p < NP; p++) c[p*CW +: CW] = CW'($urandom() % ((id % 2) ? 3 : 64));
         ex = model(lookup(8'(id)) & en, c, mrr);
         head(8'(id), en, c);
         if (ex < 0) begin
            chk(res_valid && res_err && res_port == 0, $sformatf("R7 sweep id %0d", id),
                int'({res_err, res_port}), 16);
         end else begin
            chk(res_valid && !res_err && int'(res_port) == ex,
                $sformatf("R3/R5/R6 sweep id %0d", id), int'(res_port), ex);
            chk(en[res_port] == 1'b1, $sformatf("R4 sweep id %0d enabled port", id),
                int'(en[res_port]), 1);
            mrr = (ex + 1) % NP;
         end
      end

      @(negedge clk);
      chk(res_valid == 0, "R2 no trailing valid", int'(res_valid), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule